// File: doc/BRIEF.md
# Autonegotiation Result Validator

This block supervises an Ethernet transceiver's autonegotiation outcome. A transceiver can claim that negotiation has finished while the link-partner ability word it captured is wrong. The validator therefore does not trust a bare "done" indication. At the moment completion is reported, it cross-checks the result against two things: a vendor health bit read from the transceiver's wake-up status bank, and the acknowledge bit of the partner ability word, which only counts when the expansion word says the partner can negotiate.

A result that fails the check causes a one-cycle restart pulse toward the negotiation engine. After the pulse, the block waits for "done" to fall and rise again before it checks once more. Each restart is counted. A result that passes the check raises a valid flag, which tells downstream link logic that it may consume the link status, and clears the count. If the configured number of restarts has already been spent and the result is still bad, the block raises a retry-exhausted flag instead and stays there. When autonegotiation is disabled, the block stays out of the way and reports the status as valid.

Top module: `aneg_validator`

## Requirements
- R1: While `an_en` is low, `result_valid_o` is high, and `restart_o` and `retry_exhausted_o` are low; taking `an_en` low also clears the retry count.
- R2: While `an_done` is low, the status inputs are not judged: `restart_o` stays low and `result_valid_o` stays low, however bad those inputs are.
- R3: If `vend_ok` is 0 in the cycle where `an_done` is sampled high, the result is rejected. `restart_o` is high in the following cycle and `result_valid_o` stays low.
- R4: If `an_exp` bit 0 (partner can negotiate) is 1 while `lp_abil` bit 14 (partner acknowledge) is 0, the result is rejected in the same way as in R3. An early-failure word `lp_abil` = 0x0001 is one such case.
- R5: If `an_exp` bit 0 is 0, the acknowledge bit has no effect, and `vend_ok` = 1 alone decides acceptance.
- R6: An accepted result sets `result_valid_o` high in the cycle after `an_done` is sampled high, with no restart.
- R7: `restart_o` lasts exactly one cycle. No further check is made until `an_done` has been seen low and then high again.
- R8: After RETRY_MAX (default 6) consecutive restarts, the next rejected result raises `retry_exhausted_o` instead of `restart_o`, and `result_valid_o` stays low. This exhausted state is held until `an_en` is taken low.
- R9: An accepted result clears the retry count, so a full RETRY_MAX restarts are available again afterwards.
- R10: During and right after reset with `an_en` high, all three outputs are low.
- R11: An accepted result is held until `an_done` falls. The block then returns to waiting and `result_valid_o` drops one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| an_en | input | 1 | Autonegotiation enabled |
| an_done | input | 1 | Negotiation engine reports completion |
| vend_ok | input | 1 | Vendor health bit from the wake-up status bank |
| lp_abil | input | ABIL_W | Link-partner ability word (bit 14 = acknowledge) |
| an_exp | input | EXP_W | Expansion word (bit 0 = partner can negotiate) |
| restart_o | output | 1 | One-cycle request to restart negotiation |
| result_valid_o | output | 1 | Negotiated result accepted, or negotiation disabled |
| retry_exhausted_o | output | 1 | Retry budget spent with the result still bad |

## Verification
If the block holds a wrong state, the ports show it one cycle after the offending `an_done` sample. Examples are a restart where valid was due, or valid raised on a bad word. A retry count that does not clear, or counts too far, stays hidden until a later check. It then shows up as `retry_exhausted_o` arriving one restart early or late, so the bench drives long runs of rejections both with and without an accepted result in between. A machine that skips the wait for `an_done` to drop would show a second `restart_o` pulse while `an_done` is held high.

// File: rtl/aneg_val_pkg.sv
package aneg_val_pkg;

  typedef enum logic [2:0] {
    S_WAIT    = 3'd0,
    S_RESTART = 3'd1,
    S_DROP    = 3'd2,
    S_OK      = 3'd3,
    S_FAIL    = 3'd4
  } av_state_e;

  // Rejection rule: vendor bit clear, or partner can negotiate but never acked.
  function automatic logic av_reject(input logic vend, input logic can_nway,
                                     input logic ack);
    return (!vend) || (can_nway && !ack);
  endfunction

endpackage

// File: rtl/aneg_val_judge.sv
module aneg_val_judge
  import aneg_val_pkg::*;
#(
  parameter int ABIL_W   = 16,
  parameter int EXP_W    = 16,
  parameter int ACK_BIT  = 14,
  parameter int NWAY_BIT = 0
) (
  input  logic              vend_ok,
  input  logic [ABIL_W-1:0] lp_abil,
  input  logic [EXP_W-1:0]  an_exp,
  output logic              bad
);
  logic ack_seen;
  logic nway_cap;

  assign ack_seen = lp_abil[ACK_BIT];
  assign nway_cap = an_exp[NWAY_BIT];
  assign bad      = av_reject(vend_ok, nway_cap, ack_seen);
endmodule

// File: rtl/aneg_val_retry_ctr.sv
module aneg_val_retry_ctr #(
  parameter int RETRY_MAX = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(RETRY_MAX + 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (clr)     count_q <= '0;
    else if (inc)     count_q <= count_q + 1'b1;
  end

  assign at_limit = (count_q == CW'(RETRY_MAX));

  // R8: the count never runs past the budget
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(RETRY_MAX));
endmodule

// File: rtl/aneg_val_fsm.sv
module aneg_val_fsm
  import aneg_val_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      an_en,
  input  logic      an_done,
  input  logic      bad,
  input  logic      at_limit,
  output av_state_e state_q,
  output logic      chk_ev,
  output logic      inc,
  output logic      clr
);
  av_state_e state_d;

  assign chk_ev = an_en && an_done && (state_q == S_WAIT);
  assign inc    = chk_ev && bad && !at_limit;
  assign clr    = !an_en || (chk_ev && !bad);

  always_comb begin
    state_d = state_q;
    if (!an_en) begin
      state_d = S_WAIT;
    end else begin
      unique case (state_q)
        S_WAIT:    if (an_done) state_d = bad ? (at_limit ? S_FAIL : S_RESTART) : S_OK;
        S_RESTART: state_d = S_DROP;
        S_DROP:    if (!an_done) state_d = S_WAIT;
        S_OK:      if (!an_done) state_d = S_WAIT;
        S_FAIL:    state_d = S_FAIL;
        default:   state_d = S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_WAIT;
    else        state_q <= state_d;
  end

  // R7: leaving the drop-wait state requires done to have fallen
  assert_drop_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q == S_DROP) && state_q == S_WAIT) |-> $past(!an_done || !an_en));
endmodule

// File: rtl/aneg_validator.sv
module aneg_validator
  import aneg_val_pkg::*;
#(
  parameter int ABIL_W    = 16,
  parameter int EXP_W     = 16,
  parameter int ACK_BIT   = 14,
  parameter int NWAY_BIT  = 0,
  parameter int RETRY_MAX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              an_en,
  input  logic              an_done,
  input  logic              vend_ok,
  input  logic [ABIL_W-1:0] lp_abil,
  input  logic [EXP_W-1:0]  an_exp,
  output logic              restart_o,
  output logic              result_valid_o,
  output logic              retry_exhausted_o
);
  logic      bad;
  logic      at_limit;
  logic      chk_ev;
  logic      inc;
  logic      clr;
  av_state_e state_q;

  aneg_val_judge #(
    .ABIL_W(ABIL_W), .EXP_W(EXP_W), .ACK_BIT(ACK_BIT), .NWAY_BIT(NWAY_BIT)
  ) judge_i (
    .vend_ok(vend_ok), .lp_abil(lp_abil), .an_exp(an_exp), .bad(bad)
  );

  aneg_val_retry_ctr #(.RETRY_MAX(RETRY_MAX)) ctr_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .at_limit(at_limit)
  );

  aneg_val_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .an_en(an_en), .an_done(an_done), .bad(bad),
    .at_limit(at_limit), .state_q(state_q), .chk_ev(chk_ev), .inc(inc), .clr(clr)
  );

  assign restart_o         = an_en && (state_q == S_RESTART);
  assign result_valid_o    = !an_en || (state_q == S_OK);
  assign retry_exhausted_o = an_en && (state_q == S_FAIL);

  // R7: restart is a single-cycle pulse
  assert_one_cycle_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);
  // R3: a restart only follows a sampled completion with a rejected word
  assert_restart_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restart_o) |-> $past(chk_ev && bad));
  // R8: valid and exhausted are exclusive
  assert_valid_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(result_valid_o && retry_exhausted_o));
  // R8: exhaustion only from a full budget
  assert_exhaust_at_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_exhausted_o) |-> $past(at_limit && bad));
  // R1: disabled negotiation never restarts
  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !an_en |-> (!restart_o && result_valid_o));
endmodule

// File: tb/aneg_validator_tb_top.sv
module aneg_validator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        an_en = 1'b1;
  logic        an_done = 1'b0;
  logic        vend_ok = 1'b0;
  logic [15:0] lp_abil = '0;
  logic [15:0] an_exp = '0;
  logic        restart_o, result_valid_o, retry_exhausted_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  aneg_validator dut_i (
    .clk(clk), .rst_n(rst_n), .an_en(an_en), .an_done(an_done), .vend_ok(vend_ok),
    .lp_abil(lp_abil), .an_exp(an_exp), .restart_o(restart_o),
    .result_valid_o(result_valid_o), .retry_exhausted_o(retry_exhausted_o)
  );

  // {vend_ok, lp_abil, an_exp}
  localparam logic [32:0] VEC [8] = '{
    {1'b1, 16'h45E1, 16'h0001},
    {1'b0, 16'h45E1, 16'h0001},
    {1'b1, 16'h0001, 16'h0001},
    {1'b1, 16'h0001, 16'h0000},
    {1'b1, 16'h05E1, 16'h0003},
    {1'b1, 16'h05E1, 16'h0002},
    {1'b0, 16'h0000, 16'h0000},
    {1'b1, 16'hFFFF, 16'hFFFF}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // Present a completion with the given words; sample one cycle later.
  task automatic complete(input logic v, input logic [15:0] lp, input logic [15:0] ex);
    @(negedge clk);
    vend_ok = v; lp_abil = lp; an_exp = ex; an_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drop_done();
    an_done = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_good(input logic v, input logic [15:0] lp, input logic [15:0] ex,
                             output logic g);
    g = v && !(ex[0] && !lp[14]);
  endtask

  initial begin
    logic g;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 restart in reset", restart_o, 1'b0);
    check("R10 valid in reset", result_valid_o, 1'b0);
    check("R10 exhausted in reset", retry_exhausted_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 valid after reset", result_valid_o, 1'b0);

    // Table walk: each vector from a fresh enable
    for (int i = 0; i < 8; i++) begin
      an_en = 1'b0;
      @(negedge clk);
      check("R1 disabled valid", result_valid_o, 1'b1);
      check("R1 disabled restart", restart_o, 1'b0);
      an_en = 1'b1;
      expect_good(VEC[i][32], VEC[i][31:16], VEC[i][15:0], g);
      complete(VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
      check(g ? "R6/R5 accept valid" : "R3/R4 reject valid", result_valid_o, g);
      check(g ? "R6/R5 accept restart" : "R3/R4 reject restart", restart_o, !g);
      drop_done();
    end

    // R2: no judgement while done is low
    an_en = 1'b0; @(negedge clk); an_en = 1'b1;
    vend_ok = 1'b0; lp_abil = 16'h0001; an_exp = 16'h0001; an_done = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check("R2 no restart", restart_o, 1'b0);
      check("R2 no valid", result_valid_o, 1'b0);
    end

    // R7: pulse lasts one cycle and no recheck while done held
    complete(1'b0, 16'h0001, 16'h0001);
    check("R7 pulse", restart_o, 1'b1);
    repeat (3) begin
      @(negedge clk);
      check("R7 no repeat", restart_o, 1'b0);
    end
    drop_done();

    // R11: accepted held until done drops
    complete(1'b1, 16'h4001, 16'h0001);
    repeat (2) @(negedge clk);
    check("R11 held", result_valid_o, 1'b1);
    an_done = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R11 drop", result_valid_o, 1'b0);

    // R8: budget of 6 restarts, then exhaustion
    an_en = 1'b0; @(negedge clk); an_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      complete(1'b0, 16'h0000, 16'h0000);
      check("R8 restart within budget", restart_o, 1'b1);
      drop_done();
    end
    complete(1'b0, 16'h0000, 16'h0000);
    check("R8 exhausted", retry_exhausted_o, 1'b1);
    check("R8 no restart", restart_o, 1'b0);
    check("R8 no valid", result_valid_o, 1'b0);
    drop_done();
    complete(1'b1, 16'h4001, 16'h0001);
    check("R8 exhausted held", retry_exhausted_o, 1'b1);
    check("R8 valid stays low", result_valid_o, 1'b0);
    an_done = 1'b0;
    an_en = 1'b0; @(negedge clk);
    check("R1 disable leaves exhausted", retry_exhausted_o, 1'b0);
    an_en = 1'b1; @(negedge clk);

    // R9: accept clears the count
    for (int k = 0; k < 3; k++) begin
      complete(1'b0, 16'h0000, 16'h0000);
      drop_done();
    end
    complete(1'b1, 16'h4001, 16'h0001);
    check("R9 accept", result_valid_o, 1'b1);
    drop_done();
    for (int k = 0; k < 6; k++) begin
      complete(1'b0, 16'h0000, 16'h0000);
      check("R9 fresh budget", restart_o, 1'b1);
      check("R9 not exhausted", retry_exhausted_o, 1'b0);
      drop_done();
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule